// File: doc/BRIEF.md
# Pin Edge Interrupt Source

This block watches a small group of general-purpose input pins and turns selected transitions on them into interrupt requests. Every pin carries two arming bits, one for low-to-high transitions and one for high-to-low transitions. The two bits are independent, so a pin can be armed for either direction alone, for both, or for neither. An armed transition latches a per-pin sticky flag. That flag is the pin's interrupt request, and a combined request is the OR of all flags. Software acknowledges a request by writing a one to the flag.

The pins are asynchronous to the block clock. Each pin passes through a synchronizer chain of configurable depth. A transition is found by comparing the synchronized level with a copy of it delayed by one cycle. A small register port selects one of four views: the rising arm bits, the falling arm bits, the sticky flags, or the synchronized pin levels.

Top module: `pin_edge_irq`

## Requirements
- R1: While reset is held and after it is released, both arm registers and all flags read zero, and `irq_o` and `irq_any_o` are low.
- R2: A low-to-high transition on a pin whose rising arm bit is set raises that pin's flag. With the default two-stage synchronizer, a pin change applied before clock edge k shows on the flag after edge k+2.
- R3: A high-to-low transition on a pin whose falling arm bit is set raises that pin's flag, with the same latency as R2.
- R4: A pin with both arm bits set flags transitions in either direction.
- R5: A pin with both arm bits clear never has its flag raised by a transition.
- R6: A write to select 2 (flags) clears every flag whose written bit is 1. Flags whose written bit is 0 keep their value.
- R7: When an armed transition and a write of 1 to the same flag land in the same cycle, the flag ends set.
- R8: `irq_o[i]` equals flag i and stays high until it is cleared. `irq_any_o` is high exactly when at least one flag is set.
- R9: Read select 3 returns the synchronized pin levels, which lag the pins by two clock edges. Writes to select 3 change nothing.
- R10: Select 0 holds the rising arm bits and select 1 holds the falling arm bits. Both are written by `wr_en` with `wr_sel` and read back unchanged. Writes to any other select leave them alone.
- R11: Clearing a pin's arm bits does not clear a flag that is already set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS | Asynchronous pin inputs |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write select: 0 rising arm, 1 falling arm, 2 flags (write 1 to clear), 3 none |
| wr_data | input | NPINS | Write data |
| rd_sel | input | 2 | Read select: 0 rising arm, 1 falling arm, 2 flags, 3 synchronized levels |
| rd_data | output | NPINS | Read data for `rd_sel`, combinational |
| irq_o | output | NPINS | Per-pin interrupt requests (the flags) |
| irq_any_o | output | 1 | OR of all flags |

## Verification
The four pins are armed in four different ways: both directions, falling only, rising only, and neither. The same pin waveform therefore separates a swapped or ignored arm bit from correct behaviour. Single rising and falling steps show that transitions are flagged only in the armed direction. They also fix the exact latency of the synchronizer and the delay stage. Acknowledge writes with mixed ones and zeros separate write-one-to-clear from plain overwrite. An acknowledge timed onto the same cycle as a fresh transition shows which of the two wins. A long stretch of random pin activity and register writes, checked each cycle against a behavioural model, covers interleavings that the directed steps miss.

// File: rtl/pin_edge_irq_pkg.sv
package pin_edge_irq_pkg;
   localparam int SEL_W = 2;
   typedef enum logic [SEL_W-1:0] {
      SEL_RISE  = 2'd0,
      SEL_FALL  = 2'd1,
      SEL_FLAG  = 2'd2,
      SEL_LEVEL = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/pin_edge_sync.sv
// Multi-stage synchronizer with one extra delayed copy used for edge finding.
module pin_edge_sync #(
   parameter int NPINS  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] async_i,
   output logic [NPINS-1:0] sync_o,
   output logic [NPINS-1:0] prev_o
);
   localparam int LAST = STAGES;

   initial begin
      if (STAGES < 2) $error("pin_edge_sync: STAGES must be at least 2");
   end

   logic [LAST:0][NPINS-1:0] chain;

   for (genvar s = 0; s <= LAST; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign sync_o = chain[LAST-1];
   assign prev_o = chain[LAST];
endmodule

// File: rtl/pin_edge_cfg.sv
// Rising and falling arm registers.
module pin_edge_cfg
   import pin_edge_irq_pkg::*;
#(
   parameter int NPINS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  reg_sel_e         wr_sel,
   input  logic [NPINS-1:0] wr_data,
   output logic [NPINS-1:0] rise_en,
   output logic [NPINS-1:0] fall_en
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_en <= '0;
         fall_en <= '0;
      end else if (wr_en) begin
         if (wr_sel == SEL_RISE) rise_en <= wr_data;
         if (wr_sel == SEL_FALL) fall_en <= wr_data;
      end
   end
endmodule

// File: rtl/pin_edge_detect.sv
// Per-pin transition qualification and sticky flags; a new hit beats a clear.
module pin_edge_detect #(
   parameter int NPINS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] sync_i,
   input  logic [NPINS-1:0] prev_i,
   input  logic [NPINS-1:0] rise_en,
   input  logic [NPINS-1:0] fall_en,
   input  logic [NPINS-1:0] clr_i,
   output logic [NPINS-1:0] hit_o,
   output logic [NPINS-1:0] flag_o
);
   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      logic went_up;
      logic went_down;
      assign went_up   = sync_i[i] & ~prev_i[i];
      assign went_down = ~sync_i[i] & prev_i[i];
      assign hit_o[i]  = (went_up & rise_en[i]) | (went_down & fall_en[i]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        flag_o[i] <= 1'b0;
         else if (hit_o[i]) flag_o[i] <= 1'b1;
         else if (clr_i[i]) flag_o[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/pin_edge_irq.sv
module pin_edge_irq
   import pin_edge_irq_pkg::*;
#(
   parameter int NPINS       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pin_i,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [NPINS-1:0] wr_data,
   input  logic [1:0]       rd_sel,
   output logic [NPINS-1:0] rd_data,
   output logic [NPINS-1:0] irq_o,
   output logic             irq_any_o
);
   initial begin
      if (NPINS < 1 || NPINS > 64) $error("pin_edge_irq: NPINS out of range");
   end

   reg_sel_e         wsel;
   logic [NPINS-1:0] sync_lvl, prev_lvl;
   logic [NPINS-1:0] rise_en, fall_en;
   logic [NPINS-1:0] clr;
   logic [NPINS-1:0] hit;
   logic [NPINS-1:0] status;

   assign wsel = reg_sel_e'(wr_sel);

   pin_edge_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(pin_i),
      .sync_o(sync_lvl), .prev_o(prev_lvl)
   );

   pin_edge_cfg #(.NPINS(NPINS)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wsel),
      .wr_data(wr_data), .rise_en(rise_en), .fall_en(fall_en)
   );

   assign clr = (wr_en && wsel == SEL_FLAG) ? wr_data : '0;

   pin_edge_detect #(.NPINS(NPINS)) u_det (
      .clk(clk), .rst_n(rst_n), .sync_i(sync_lvl), .prev_i(prev_lvl),
      .rise_en(rise_en), .fall_en(fall_en), .clr_i(clr),
      .hit_o(hit), .flag_o(status)
   );

   always_comb begin
      case (reg_sel_e'(rd_sel))
         SEL_RISE: rd_data = rise_en;
         SEL_FALL: rd_data = fall_en;
         SEL_FLAG: rd_data = status;
         default:  rd_data = sync_lvl;
      endcase
   end

   assign irq_o     = status;
   assign irq_any_o = |status;
endmodule

// File: rtl/pin_edge_irq_chk.sv
module pin_edge_irq_chk #(
   parameter int NPINS = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       wr_sel,
   input logic [NPINS-1:0] wr_data,
   input logic [NPINS-1:0] rise_en,
   input logic [NPINS-1:0] fall_en,
   input logic [NPINS-1:0] hit,
   input logic [NPINS-1:0] status,
   input logic [NPINS-1:0] irq_o,
   input logic             irq_any_o
);
   // R5
   no_arm_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((status & ~$past(status)) & ~($past(rise_en) | $past(fall_en))) == '0);

   // R6
   clear_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((~irq_o & $past(irq_o)) &
       ~(($past(wr_en) && $past(wr_sel) == 2'd2) ? $past(wr_data) : '0)) == '0);

   // R7
   hit_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status & $past(hit)) == $past(hit));

   // R8
   any_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_any_o == (irq_o != '0));

   // R10
   rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !($past(wr_en) && $past(wr_sel) == 2'd0) |-> $stable(rise_en));

   // R10
   fall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !($past(wr_en) && $past(wr_sel) == 2'd1) |-> $stable(fall_en));
endmodule

bind pin_edge_irq pin_edge_irq_chk #(.NPINS(NPINS)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
   .wr_data(wr_data), .rise_en(rise_en), .fall_en(fall_en),
   .hit(hit), .status(status), .irq_o(irq_o), .irq_any_o(irq_any_o)
);

// File: tb/pin_edge_irq_tb_top.sv
`timescale 1ns/1ps
module pin_edge_irq_tb_top;
   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] pin_i = '0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_sel = '0;
   logic [N-1:0] wr_data = '0;
   logic [1:0]   rd_sel = '0;
   logic [N-1:0] rd_data;
   logic [N-1:0] irq_o;
   logic         irq_any_o;

   int    n_chk = 0;
   int    n_bad = 0;
   bit    done = 0;
   string phase = "R1";

   always #4 clk = ~clk;

   pin_edge_irq #(.NPINS(N), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
      .rd_data(rd_data), .irq_o(irq_o), .irq_any_o(irq_any_o)
   );

   // Behavioural model: pin history as a queue of per-edge samples.
   logic [N-1:0] hist[$];
   logic [N-1:0] m_rise, m_fall, m_flag, m_lvl;

   always @(posedge clk) begin
      if (!rst_n) begin
         hist = {'0, '0, '0};
         m_rise = '0; m_fall = '0; m_flag = '0; m_lvl = '0;
      end else begin
         logic [N-1:0] cur, old, ups, downs, clr_mask;
         cur = hist[hist.size()-2];
         old = hist[hist.size()-3];
         ups   = cur & ~old;
         downs = ~cur & old;
         clr_mask = (wr_en && wr_sel == 2'd2) ? wr_data : '0;
         m_flag = (m_flag & ~clr_mask) | (ups & m_rise) | (downs & m_fall);
         if (wr_en && wr_sel == 2'd0) m_rise = wr_data;
         if (wr_en && wr_sel == 2'd1) m_fall = wr_data;
         hist.push_back(pin_i);
         if (hist.size() > 8) void'(hist.pop_front());
         m_lvl = hist[hist.size()-2];
      end
   end

   task automatic cmp(string what, logic [N-1:0] act, logic [N-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b at %0t", phase, what, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      #2;
      if (!done) begin
         logic [N-1:0] exp_rd;
         case (rd_sel)
            2'd0: exp_rd = m_rise;
            2'd1: exp_rd = m_fall;
            2'd2: exp_rd = m_flag;
            default: exp_rd = m_lvl;
         endcase
         cmp("irq_o", irq_o, m_flag);
         cmp("irq_any_o", {{(N-1){1'b0}}, irq_any_o}, {{(N-1){1'b0}}, |m_flag});
         cmp("rd_data", rd_data, exp_rd);
      end
   end

   task automatic step(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(logic [1:0] sel, logic [N-1:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic finish_run();
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(8 * 100000);
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      // R1: reset state
      phase = "R1";
      step(3);
      rst_n = 1'b1;
      step(2);
      rd_sel = 2'd2; step(1);
      // R10: arm registers; pin0 both, pin1 fall, pin2 rise, pin3 none
      phase = "R10";
      wr(2'd0, 4'b0101);
      wr(2'd1, 4'b0011);
      rd_sel = 2'd0; step(1);
      rd_sel = 2'd1; step(1);
      wr(2'd3, 4'b1111);
      wr(2'd2, 4'b1111);
      rd_sel = 2'd0; step(1);
      // R2: rising steps on every pin
      phase = "R2";
      rd_sel = 2'd2;
      pin_i = 4'b1111; step(4);
      // R8: flags held until acknowledged
      phase = "R8";
      step(3);
      // R6: mixed acknowledge
      phase = "R6";
      wr(2'd2, 4'b0100); step(1);
      wr(2'd2, 4'b0001); step(1);
      // R3: falling steps
      phase = "R3";
      pin_i = 4'b0000; step(4);
      // R5: unarmed pin3 toggles alone
      phase = "R5";
      wr(2'd2, 4'b1111);
      pin_i = 4'b1000; step(4);
      pin_i = 4'b0000; step(4);
      // R4: pin0 both directions
      phase = "R4";
      pin_i = 4'b0001; step(4);
      wr(2'd2, 4'b0001);
      pin_i = 4'b0000; step(4);
      // R9: level readback lags pins
      phase = "R9";
      rd_sel = 2'd3;
      pin_i = 4'b1010; step(1); step(1); step(2);
      pin_i = 4'b0000; step(4);
      rd_sel = 2'd2;
      wr(2'd2, 4'b1111);
      // R7: acknowledge in same cycle as the flag-setting hit
      phase = "R7";
      pin_i = 4'b0100;
      step(2);
      wr(2'd2, 4'b0100);
      step(2);
      // R11: disarm keeps existing flags
      phase = "R11";
      wr(2'd0, 4'b0000);
      wr(2'd1, 4'b0000);
      step(2);
      pin_i = 4'b0000; step(4);
      // Random interleaving
      phase = "R2/R3/R6 random";
      for (int k = 0; k < 400; k++) begin
         pin_i  = N'($urandom);
         rd_sel = 2'($urandom);
         if (($urandom % 4) == 0) begin
            wr_en = 1'b1; wr_sel = 2'($urandom); wr_data = N'($urandom);
         end else begin
            wr_en = 1'b0;
         end
         step(1);
      end
      wr_en = 1'b0;
      step(2);
      finish_run();
   end
endmodule